// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges five reset causes into one internal core reset for a small microcontroller: an active-low external pin, a self-clearing software reset request, a watchdog overflow pulse, a power-on or low-voltage level, and a clock-supervisor fault. When any cause is active, the core reset is asserted at the next clock edge. The core stays in reset until every cause has been gone for two synchronizer cycles. After that, the block requests a one-cycle mode fetch, in which the core reads its mode data and reset vector.

The external pin passes through a two-flop synchronizer and a low-level filter before it can start a reset. An oscillator-stabilization wait is added before the mode fetch in two cases: the reset involved the power detector, or the device is in subclock or stop mode when reset is released. A five-bit cause register records the latest reset event. Software clears its bits by writing one to them.

Top module: `rstctl_top`

## Requirements
- R1: While `rst_n` is low, `core_rst_n` and `fetch_req` are low and `cause_flags` reads 5'b01000. After `rst_n` rises, the stabilization wait always runs before the first mode fetch.
- R2: Cause bit positions are: bit 0 external pin, bit 1 software, bit 2 watchdog, bit 3 power or low voltage, bit 4 clock fault. Any active cause drives `core_rst_n` low from the next clock edge on.
- R3: A low pulse on `ext_rst_n` starts a reset only if it is sampled low on at least FILT_LEN consecutive clock edges. Shorter pulses leave `core_rst_n` high and the flags unchanged.
- R4: Without a stabilization wait, `core_rst_n` rises and `fetch_req` pulses three clock edges after the last edge that saw a cause. For the external pin this becomes six edges after the pin is released.
- R5: STAB_CYC extra cycles are inserted before the mode fetch in two cases: `pwr_bad` was seen during the reset, or `slow_mode` is high at the release edge.
- R6: A `sw_rst_wr` pulse while the core runs starts one reset. The request clears itself, so after the mode fetch the core stays running. A `sw_rst_wr` pulse while the core is in reset is ignored.
- R7: A reset event that starts from the running state clears every flag except bit 3. It then sets the bits of all causes active in that cycle. Causes active later in the same reset also set their bits.
- R8: A cycle with `flag_clr_we` high clears each flag whose `flag_clr_mask` bit is 1. A cause that is active in the same cycle wins, and its bit stays set.
- R9: Bit 3 is cleared only by a write-one-to-clear, never by another reset cause.
- R10: `fetch_req` is high only while `core_rst_n` is high, and never for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Synchronous active-low reset of the controller (always-on power-up) |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| sw_rst_wr | input | 1 | Pulse: write of 1 to the software reset bit |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| pwr_bad | input | 1 | Power-on or low-voltage detector level, high = bad |
| clk_fault | input | 1 | Clock supervisor: abnormal oscillation stop |
| slow_mode | input | 1 | Device is in subclock or stop mode |
| flag_clr_we | input | 1 | Write strobe for the cause-flag register |
| flag_clr_mask | input | 5 | Bits to clear (write one to clear) |
| core_rst_n | output | 1 | Internal core reset, active low |
| fetch_req | output | 1 | One-cycle mode-fetch request |
| cause_flags | output | 5 | Latest reset causes, bit order per R2 |

## Verification
Some properties are checked on every cycle: any watchdog, power or clock-fault input pulls the core into reset on the next edge; the mode-fetch pulse coincides with the rising core reset and never repeats; the power flag persists unless it is written; and clearing and setting of the watchdog flag follow their rules. Other behaviour can only be shown by the bench's scenarios. These include the exact release latencies, swept over all five causes with the slow mode off and on, and the filter's accept or reject boundary, swept over pulse lengths. They also include the software request firing only once and the latest-cause flag contents.

// File: rtl/rstctl_pkg.sv
`timescale 1ns/1ps
// rstctl_pkg: shared constants and types for the reset controller.
// Assumes: cause bit positions are fixed and decoded by software.
package rstctl_pkg;
    localparam int NCAUSE    = 5;
    localparam int CAUSE_EXT = 0;
    localparam int CAUSE_SW  = 1;
    localparam int CAUSE_WDT = 2;
    localparam int CAUSE_PWR = 3;
    localparam int CAUSE_CLK = 4;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_STAB  = 2'd2,
        ST_FETCH = 2'd3
    } seq_state_t;
endpackage

// File: rtl/rstctl_pinfilt.sv
`timescale 1ns/1ps
// rstctl_pinfilt: synchronizes the asynchronous active-low reset pin and
// accepts it only after FILT_LEN consecutive low samples.
// Assumes: clk runs whenever the pin must be seen; FILT_LEN >= 1.
module rstctl_pinfilt #(
    parameter int FILT_LEN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic accepted
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          low_cnt_q;

    // Bring the pin into the clock domain through a flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
    end

    // Count consecutive low samples, saturating at the acceptance width.
    always_ff @(posedge clk) begin
        if (!rst_n)                    low_cnt_q <= '0;
        else if (sync_q[SYNC_STAGES-1]) low_cnt_q <= '0;
        else if (low_cnt_q != FULL)    low_cnt_q <= low_cnt_q + 1'b1;
    end

    assign accepted = (low_cnt_q == FULL);
endmodule

// File: rtl/rstctl_seq.sv
`timescale 1ns/1ps
// rstctl_seq: reset sequencer. Holds the core in reset while any cause is
// active, synchronizes the release over two cycles, optionally waits for
// oscillator stabilization, then issues a one-cycle mode-fetch request.
// Assumes: STAB_CYC >= 2; causes are already in the clock domain.
module rstctl_seq
    import rstctl_pkg::*;
#(
    parameter int STAB_CYC = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_acc,
    input  logic              sw_rst_wr,
    input  logic              wdt_ovf,
    input  logic              pwr_bad,
    input  logic              clk_fault,
    input  logic              slow_mode,
    output logic [NCAUSE-1:0] cause_vec,
    output logic              new_evt,
    output logic              core_rst_n,
    output logic              fetch_req
);
    localparam int SCW = $clog2(STAB_CYC);
    localparam logic [SCW-1:0] STAB_LAST = SCW'(STAB_CYC - 1);

    seq_state_t     state_q;
    logic [1:0]     rel_q;
    logic           sw_req_q;
    logic           need_osc_q;
    logic [SCW-1:0] stab_q;
    logic           any_cause;

    assign cause_vec = {clk_fault, pwr_bad, wdt_ovf, sw_req_q, ext_acc};
    assign any_cause = |cause_vec;
    assign new_evt   = any_cause && (state_q == ST_RUN);

    // Software request: taken only while running, dropped once the reset starts.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_req_q <= 1'b0;
        else        sw_req_q <= (state_q == ST_RUN) && !any_cause && sw_rst_wr;
    end

    // Remember that the oscillator must settle (power-up or detector event).
    always_ff @(posedge clk) begin
        if (!rst_n)                  need_osc_q <= 1'b1;
        else if (pwr_bad)            need_osc_q <= 1'b1;
        else if (state_q == ST_FETCH) need_osc_q <= 1'b0;
    end

    // Main sequence: hold, synchronized release, optional wait, fetch, run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            rel_q   <= 2'b00;
            stab_q  <= '0;
        end else if (any_cause) begin
            state_q <= ST_HOLD;
            rel_q   <= 2'b00;
        end else begin
            unique case (state_q)
                ST_HOLD: begin
                    rel_q <= {rel_q[0], 1'b1};
                    if (rel_q[1]) begin
                        stab_q  <= '0;
                        state_q <= (need_osc_q || slow_mode) ? ST_STAB : ST_FETCH;
                    end
                end
                ST_STAB: begin
                    if (stab_q == STAB_LAST) state_q <= ST_FETCH;
                    else                     stab_q  <= stab_q + 1'b1;
                end
                ST_FETCH: state_q <= ST_RUN;
                default:  state_q <= ST_RUN;
            endcase
        end
    end

    assign core_rst_n = (state_q == ST_RUN) || (state_q == ST_FETCH);
    assign fetch_req  = (state_q == ST_FETCH);
endmodule

// File: rtl/rstctl_flags.sv
`timescale 1ns/1ps
// rstctl_flags: latest-cause flag register with write-one-to-clear.
// A new reset event wipes all flags but the power flag; active causes set.
// Assumes: set has priority over a clear in the same cycle.
module rstctl_flags
    import rstctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCAUSE-1:0] cause_vec,
    input  logic              new_evt,
    input  logic              clr_we,
    input  logic [NCAUSE-1:0] clr_mask,
    output logic [NCAUSE-1:0] flags
);
    for (genvar i = 0; i < NCAUSE; i++) begin : g_flag
        localparam bit IS_PWR = (i == CAUSE_PWR);
        // One flag bit: set by its cause, kept unless cleared or superseded.
        always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= IS_PWR;
            else        flags[i] <= cause_vec[i]
                                  | (flags[i] & ~(clr_we & clr_mask[i])
                                              & (IS_PWR | ~new_evt));
        end
    end
endmodule

// File: rtl/rstctl_top.sv
`timescale 1ns/1ps
// rstctl_top: multi-source reset controller. Filters the external pin,
// sequences the core reset release and records the latest cause.
// Assumes: all inputs other than ext_rst_n are synchronous to clk.
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int FILT_LEN = 4,
    parameter int STAB_CYC = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_rst_n,
    input  logic        sw_rst_wr,
    input  logic        wdt_ovf,
    input  logic        pwr_bad,
    input  logic        clk_fault,
    input  logic        slow_mode,
    input  logic        flag_clr_we,
    input  logic [4:0]  flag_clr_mask,
    output logic        core_rst_n,
    output logic        fetch_req,
    output logic [4:0]  cause_flags
);
    logic              ext_acc;
    logic [NCAUSE-1:0] cause_vec;
    logic              new_evt;

    rstctl_pinfilt #(.FILT_LEN(FILT_LEN), .SYNC_STAGES(2)) i_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (ext_rst_n),
        .accepted (ext_acc)
    );

    rstctl_seq #(.STAB_CYC(STAB_CYC)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_acc    (ext_acc),
        .sw_rst_wr  (sw_rst_wr),
        .wdt_ovf    (wdt_ovf),
        .pwr_bad    (pwr_bad),
        .clk_fault  (clk_fault),
        .slow_mode  (slow_mode),
        .cause_vec  (cause_vec),
        .new_evt    (new_evt),
        .core_rst_n (core_rst_n),
        .fetch_req  (fetch_req)
    );

    rstctl_flags i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause_vec (cause_vec),
        .new_evt   (new_evt),
        .clr_we    (flag_clr_we),
        .clr_mask  (flag_clr_mask),
        .flags     (cause_flags)
    );
endmodule

// File: rtl/rstctl_chk.sv
`timescale 1ns/1ps
// rstctl_chk: port-level properties of the reset controller, bound to the top.
// Assumes: rst_n is the controller's synchronous reset.
module rstctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wdt_ovf,
    input logic       pwr_bad,
    input logic       clk_fault,
    input logic       flag_clr_we,
    input logic [4:0] flag_clr_mask,
    input logic       core_rst_n,
    input logic       fetch_req,
    input logic [4:0] cause_flags
);
    AST_CAUSE_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_ovf || pwr_bad || clk_fault) |=> !core_rst_n); // R2
    AST_FETCH_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> fetch_req); // R4
    AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> !fetch_req); // R10
    AST_FETCH_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> core_rst_n); // R10
    AST_WDT_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_ovf |=> cause_flags[2]); // R7
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_we && flag_clr_mask[2] && !wdt_ovf) |=> !cause_flags[2]); // R8
    AST_PWR_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_flags[3] && !(flag_clr_we && flag_clr_mask[3])) |=> cause_flags[3]); // R9
endmodule

bind rstctl_top rstctl_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wdt_ovf       (wdt_ovf),
    .pwr_bad       (pwr_bad),
    .clk_fault     (clk_fault),
    .flag_clr_we   (flag_clr_we),
    .flag_clr_mask (flag_clr_mask),
    .core_rst_n    (core_rst_n),
    .fetch_req     (fetch_req),
    .cause_flags   (cause_flags)
);

// File: tb/test_rstctl_top.sv
`timescale 1ns/1ps
module test_rstctl_top;
    localparam int FILT = 4;
    localparam int STAB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       sw_rst_wr = 1'b0;
    logic       wdt_ovf = 1'b0;
    logic       pwr_bad = 1'b0;
    logic       clk_fault = 1'b0;
    logic       slow_mode = 1'b0;
    logic       flag_clr_we = 1'b0;
    logic [4:0] flag_clr_mask = '0;
    logic       core_rst_n;
    logic       fetch_req;
    logic [4:0] cause_flags;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [4:0] exp_flags;

    always #10 clk = ~clk;

    rstctl_top #(.FILT_LEN(FILT), .STAB_CYC(STAB)) i_rstctl_top (
        .clk (clk), .rst_n (rst_n), .ext_rst_n (ext_rst_n),
        .sw_rst_wr (sw_rst_wr), .wdt_ovf (wdt_ovf), .pwr_bad (pwr_bad),
        .clk_fault (clk_fault), .slow_mode (slow_mode),
        .flag_clr_we (flag_clr_we), .flag_clr_mask (flag_clr_mask),
        .core_rst_n (core_rst_n), .fetch_req (fetch_req),
        .cause_flags (cause_flags)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count falling edges until fetch_req is seen; -1 on timeout.
    task automatic wait_fetch(output int k);
        k = 0;
        while (k < 100) begin
            @(negedge clk);
            k++;
            if (fetch_req) return;
        end
        k = -1;
    endtask

    // After a fetch: pulse ends and the core keeps running.
    task automatic check_after(input string req);
        int up;
        @(negedge clk);
        chk({req, " R10 fetch single"}, int'(fetch_req), 0);
        up = 1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!core_rst_n) up = 0;
        end
        chk({req, " R6 core stays running"}, up, 1);
    endtask

    // Apply one cause for one cycle (pin: 8 cycles) and check latency/flags.
    task automatic run_cause(input int idx, input bit slow);
        int k, lat;
        @(negedge clk);
        slow_mode = slow;
        case (idx)
            0: ext_rst_n = 1'b0;
            1: sw_rst_wr = 1'b1;
            2: wdt_ovf = 1'b1;
            3: pwr_bad = 1'b1;
            default: clk_fault = 1'b1;
        endcase
        if (idx == 0) repeat (7) @(negedge clk);
        @(negedge clk);
        ext_rst_n = 1'b1; sw_rst_wr = 1'b0; wdt_ovf = 1'b0;
        pwr_bad = 1'b0; clk_fault = 1'b0;
        if (idx >= 2) chk("R2 reset asserted next edge", int'(core_rst_n), 0);
        exp_flags = (exp_flags & 5'b01000) | 5'(1 << idx);
        lat = (idx == 0) ? 6 : (idx == 1) ? 4 : 3;
        if (idx == 3 || slow) lat += STAB;
        wait_fetch(k);
        chk($sformatf("R4 R5 latency cause=%0d slow=%0d", idx, slow), k, lat);
        chk("R7 R9 cause flags", int'(cause_flags), int'(exp_flags));
        check_after("cause run");
    endtask

    initial begin
        int k;
        exp_flags = 5'b01000;
        repeat (3) @(negedge clk);
        chk("R1 reset core_rst_n", int'(core_rst_n), 0);
        chk("R1 reset fetch_req", int'(fetch_req), 0);
        chk("R1 reset flags", int'(cause_flags), 8);
        rst_n = 1'b1;
        wait_fetch(k);
        chk("R1 R5 first release latency", k, 3 + STAB);
        chk("R1 flags after release", int'(cause_flags), 8);
        check_after("R1");

        // Sweep every cause with and without slow mode.
        for (int s = 0; s < 2; s++)
            for (int c = 0; c < 5; c++)
                run_cause(c, s[0]);
        slow_mode = 1'b0;

        // Write-one-to-clear of all flags.
        @(negedge clk);
        flag_clr_we = 1'b1; flag_clr_mask = 5'b11111;
        @(negedge clk);
        flag_clr_we = 1'b0; flag_clr_mask = '0;
        chk("R8 w1c clears all", int'(cause_flags), 0);
        exp_flags = '0;

        // Filter boundary: short pulses are rejected.
        for (int len = 1; len < FILT; len++) begin
            int up;
            @(negedge clk);
            ext_rst_n = 1'b0;
            repeat (len) @(negedge clk);
            ext_rst_n = 1'b1;
            up = 1;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (!core_rst_n) up = 0;
            end
            chk($sformatf("R3 short pulse len=%0d ignored", len), up, 1);
            chk("R3 short pulse flags", int'(cause_flags), 0);
        end
        // Pulses at and above the width are accepted.
        for (int len = FILT; len < FILT + 3; len++) begin
            @(negedge clk);
            ext_rst_n = 1'b0;
            repeat (len) @(negedge clk);
            ext_rst_n = 1'b1;
            wait_fetch(k);
            chk($sformatf("R3 R4 pulse len=%0d latency", len), k, 6);
            chk("R3 pin flag", int'(cause_flags), 1);
            check_after("R3");
        end

        // Set wins over clear in the same cycle.
        @(negedge clk);
        wdt_ovf = 1'b1; flag_clr_we = 1'b1; flag_clr_mask = 5'b11111;
        @(negedge clk);
        wdt_ovf = 1'b0; flag_clr_we = 1'b0; flag_clr_mask = '0;
        chk("R8 set beats clear", int'(cause_flags), 4);
        wait_fetch(k);
        chk("R4 latency after set-vs-clear", k, 3);
        check_after("R8");

        // Two causes in one cycle both recorded.
        @(negedge clk);
        wdt_ovf = 1'b1; clk_fault = 1'b1;
        @(negedge clk);
        wdt_ovf = 1'b0; clk_fault = 1'b0;
        wait_fetch(k);
        chk("R4 latency dual cause", k, 3);
        chk("R7 dual cause flags", int'(cause_flags), 5'b10100);
        check_after("R7");

        // Software write during reset is ignored.
        @(negedge clk);
        wdt_ovf = 1'b1;
        @(negedge clk);
        wdt_ovf = 1'b0; sw_rst_wr = 1'b1;
        @(negedge clk);
        sw_rst_wr = 1'b0;
        wait_fetch(k);
        chk("R6 sw write in reset ignored latency", k, 2);
        chk("R6 sw write in reset no flag", int'(cause_flags), 4);
        check_after("R6");

        // Power flag survives another cause.
        @(negedge clk);
        pwr_bad = 1'b1;
        @(negedge clk);
        pwr_bad = 1'b0;
        wait_fetch(k);
        chk("R5 pwr latency", k, 3 + STAB);
        @(negedge clk);
        clk_fault = 1'b1;
        @(negedge clk);
        clk_fault = 1'b0;
        wait_fetch(k);
        chk("R4 latency no stab after pwr cleared", k, 3);
        chk("R9 pwr flag kept", int'(cause_flags), 5'b11000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog R4 actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule